// File: doc/BRIEF.md
# Clock Level Best-Match Selector

This block picks, from a short table of available source-clock frequencies, the entry that best serves a requested serial clock rate when the chosen source is later divided down by a whole number. For each valid entry it works out the smallest integer divider that keeps the divided rate at or below the request. It then measures how far that divided rate falls short of the request and keeps the entry with the smallest shortfall.

Software or a sequencer fills the table through a one-entry-per-cycle write port and sets a valid count. It then pulses `start` with the requested rate and an exact-match flag. The block walks the valid entries in index order through one shared shift-subtract divider and raises `done` with the winning index, the winning frequency and an `error` flag. A search ends early as soon as an entry divides down to the request with no shortfall.

Top module: `clk_match_sel`

## Requirements
- R1: Only table indices below the valid count take part in a search; a count above MAX_LEVELS (32) is treated as MAX_LEVELS, and entries written at or above the count never win.
- R2: For an entry F and a request Q the divider is F/Q rounded up, computed as the truncated quotient plus one when the remainder is non-zero.
- R3: The shortfall of an entry is Q minus F divided by its divider with truncation; the reported index and frequency are those of the entry with the smallest shortfall.
- R4: An entry replaces the current best only when its shortfall is strictly smaller, so on a tie the lowest index wins.
- R5: When an entry gives zero shortfall the search stops at that entry and reports it as a success without visiting later entries.
- R6: With `exact` set and no entry giving zero shortfall, the search ends with `error` high; with `exact` clear the best entry is reported with `error` low.
- R7: A valid count of zero or a requested rate of zero ends the search with `error` high, and no division is started.
- R8: `done` stays high, and `best_idx` and `best_freq` stay unchanged, until the next accepted start; a `start` pulse while `busy` is high is ignored.
- R9: A table entry of zero gets a divider of zero and a divided rate of zero, so its shortfall equals the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 5 | Table write index |
| tbl_wdata | input | 32 | Frequency written into the table |
| tbl_count | input | 6 | Number of valid table entries |
| start | input | 1 | Start pulse, taken only while idle |
| req_freq | input | 32 | Requested serial clock rate |
| exact | input | 1 | Demand a zero-shortfall entry |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid, held until next start |
| error | output | 1 | Search failed (empty table, zero request, or no exact hit) |
| best_idx | output | 5 | Index of the chosen entry |
| best_freq | output | 32 | Frequency of the chosen entry |

## Verification
The assertions assume that neither the table contents nor `tbl_count` change while `busy` is high. The block reads the current entry straight from the table at each step and latches only the request, the flag and the count. The stimulus therefore writes the table and changes the count only between searches, when `busy` is low. It raises `start` for a single cycle at a time and applies a stray start during a search only to show that it is ignored.

// File: rtl/clk_match_pkg.sv
package clk_match_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV1_GO,
    ST_DIV1_WAIT,
    ST_DIV2_GO,
    ST_DIV2_WAIT,
    ST_SCORE,
    ST_REJECT
  } search_state_e;

endpackage

// File: rtl/clk_level_table.sv
module clk_level_table #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [W-1:0] slot;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           slot <= '0;
      else if (we && (waddr == AW'(g)))     slot <= wdata;
    end
    assign ent[g] = slot;
  end

  assign rdata = ent[raddr];

endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         fin
);

  logic [W-1:0]  quot_q, rem_q, dvsr_q, dvnd_q;
  logic [CW-1:0] cnt_q;
  logic          active_q, fin_q;
  logic [W:0]    shifted, trial;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quot_q[W-1]};
    trial   = shifted - {1'b0, dvsr_q};
    fits    = ~trial[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q   <= '0;
      rem_q    <= '0;
      dvsr_q   <= '0;
      dvnd_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      fin_q    <= 1'b0;
    end else if (go) begin
      quot_q   <= dividend;
      dvnd_q   <= dividend;
      rem_q    <= '0;
      dvsr_q   <= divisor;
      cnt_q    <= CW'(W);
      active_q <= 1'b1;
      fin_q    <= 1'b0;
    end else if (active_q) begin
      rem_q  <= fits ? trial[W-1:0] : shifted[W-1:0];
      quot_q <= {quot_q[W-2:0], fits};
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        active_q <= 1'b0;
        fin_q    <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign quot = quot_q;
  assign rem  = rem_q;
  assign fin  = fin_q;

  AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q && (dvsr_q != '0) |->
      ({{W{1'b0}}, quot_q} * {{W{1'b0}}, dvsr_q} + {{W{1'b0}}, rem_q}) == {{W{1'b0}}, dvnd_q}); // R2
  AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q && (dvsr_q != '0) |-> rem_q < dvsr_q); // R3

endmodule

// File: rtl/clk_match_ctrl.sv
module clk_match_ctrl
  import clk_match_pkg::*;
#(
  parameter int FREQ_W     = 32,
  parameter int MAX_LEVELS = 32,
  localparam int IDX_W     = $clog2(MAX_LEVELS),
  localparam int CNT_W     = $clog2(MAX_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic              exact,
  input  logic [CNT_W-1:0]  tbl_count,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [FREQ_W-1:0] rd_data,
  output logic              div_go,
  output logic [FREQ_W-1:0] div_dividend,
  output logic [FREQ_W-1:0] div_divisor,
  input  logic              div_fin,
  input  logic [FREQ_W-1:0] div_quot,
  input  logic [FREQ_W-1:0] div_rem,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [IDX_W-1:0]  best_idx,
  output logic [FREQ_W-1:0] best_freq
);

  // divider for one entry: truncated quotient bumped when anything is left over
  function automatic logic [FREQ_W-1:0] round_up_div(input logic [FREQ_W-1:0] q,
                                                     input logic [FREQ_W-1:0] r);
    return q + {{(FREQ_W-1){1'b0}}, (r != '0)};
  endfunction

  // how far the divided rate falls short of the request
  function automatic logic [FREQ_W-1:0] shortfall(input logic [FREQ_W-1:0] want,
                                                  input logic [FREQ_W-1:0] got);
    return want - got;
  endfunction

  search_state_e     state_q;
  logic [FREQ_W-1:0] req_q, div_q, entry_err_q, best_err_q;
  logic              exact_q, have_best_q;
  logic [IDX_W-1:0]  idx_q, last_idx_q, best_idx_q;
  logic [FREQ_W-1:0] best_freq_q;
  logic              done_q, error_q;

  // named events
  logic             accept, reject_now, improve, hit, scan_end;
  logic [CNT_W-1:0] n_eff;
  logic [FREQ_W-1:0] ceil_div;

  assign n_eff      = (tbl_count > CNT_W'(MAX_LEVELS)) ? CNT_W'(MAX_LEVELS) : tbl_count;
  assign accept     = start && (state_q == ST_IDLE);
  assign reject_now = (req_freq == '0) || (n_eff == '0);
  assign improve    = (state_q == ST_SCORE) && (entry_err_q < best_err_q);
  assign hit        = (state_q == ST_SCORE) && (entry_err_q == '0);
  assign scan_end   = (state_q == ST_SCORE) && (idx_q == last_idx_q);
  assign ceil_div   = round_up_div(div_quot, div_rem);

  assign rd_idx       = idx_q;
  assign div_go       = (state_q == ST_DIV1_GO) || (state_q == ST_DIV2_GO);
  assign div_dividend = rd_data;
  assign div_divisor  = (state_q == ST_DIV2_GO) ? div_q : req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_q       <= '0;
      exact_q     <= 1'b0;
      div_q       <= '0;
      entry_err_q <= '0;
      best_err_q  <= '1;
      have_best_q <= 1'b0;
      idx_q       <= '0;
      last_idx_q  <= '0;
      best_idx_q  <= '0;
      best_freq_q <= '0;
      done_q      <= 1'b0;
      error_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            req_q       <= req_freq;
            exact_q     <= exact;
            last_idx_q  <= IDX_W'(n_eff - 1'b1);
            idx_q       <= '0;
            best_err_q  <= '1;
            have_best_q <= 1'b0;
            best_idx_q  <= '0;
            best_freq_q <= '0;
            done_q      <= 1'b0;
            error_q     <= 1'b0;
            state_q     <= reject_now ? ST_REJECT : ST_DIV1_GO;
          end
        end
        ST_REJECT: begin
          done_q  <= 1'b1;
          error_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_DIV1_GO: state_q <= ST_DIV1_WAIT;
        ST_DIV1_WAIT: begin
          if (div_fin) begin
            div_q <= ceil_div;
            if (ceil_div == '0) begin
              entry_err_q <= req_q;
              state_q     <= ST_SCORE;
            end else begin
              state_q <= ST_DIV2_GO;
            end
          end
        end
        ST_DIV2_GO: state_q <= ST_DIV2_WAIT;
        ST_DIV2_WAIT: begin
          if (div_fin) begin
            entry_err_q <= shortfall(req_q, div_quot);
            state_q     <= ST_SCORE;
          end
        end
        ST_SCORE: begin
          if (improve) begin
            best_err_q  <= entry_err_q;
            best_idx_q  <= idx_q;
            best_freq_q <= rd_data;
            have_best_q <= 1'b1;
          end
          if (hit) begin
            done_q  <= 1'b1;
            error_q <= 1'b0;
            state_q <= ST_IDLE;
          end else if (scan_end) begin
            done_q  <= 1'b1;
            error_q <= exact_q || !(have_best_q || improve);
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_DIV1_GO;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign error     = error_q;
  assign best_idx  = best_idx_q;
  assign best_freq = best_freq_q;

  AST_REJECT_ZERO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (req_freq == '0) |=> !done ##1 (done && error)); // R7
  AST_NO_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> div_divisor != '0); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !accept |=> done && $stable(best_idx) && $stable(best_freq)); // R8
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R8
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(req_q) && $stable(exact_q)); // R8
  AST_BEST_NONINCREASE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> best_err_q <= $past(best_err_q)); // R4
  AST_EXACT_ZERO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && !error && exact_q |-> best_err_q == '0); // R6
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !error |-> best_idx <= last_idx_q); // R1

endmodule

// File: rtl/clk_match_sel.sv
module clk_match_sel #(
  parameter int FREQ_W     = 32,
  parameter int MAX_LEVELS = 32,
  localparam int IDX_W     = $clog2(MAX_LEVELS),
  localparam int CNT_W     = $clog2(MAX_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_waddr,
  input  logic [FREQ_W-1:0] tbl_wdata,
  input  logic [CNT_W-1:0]  tbl_count,
  input  logic              start,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic              exact,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [IDX_W-1:0]  best_idx,
  output logic [FREQ_W-1:0] best_freq
);

  logic [IDX_W-1:0]  rd_idx;
  logic [FREQ_W-1:0] rd_data;
  logic              div_go, div_fin;
  logic [FREQ_W-1:0] div_dividend, div_divisor, div_quot, div_rem;

  clk_level_table #(.W(FREQ_W), .DEPTH(MAX_LEVELS)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  seq_divider #(.W(FREQ_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_dividend),
    .divisor  (div_divisor),
    .quot     (div_quot),
    .rem      (div_rem),
    .fin      (div_fin)
  );

  clk_match_ctrl #(.FREQ_W(FREQ_W), .MAX_LEVELS(MAX_LEVELS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .req_freq     (req_freq),
    .exact        (exact),
    .tbl_count    (tbl_count),
    .rd_idx       (rd_idx),
    .rd_data      (rd_data),
    .div_go       (div_go),
    .div_dividend (div_dividend),
    .div_divisor  (div_divisor),
    .div_fin      (div_fin),
    .div_quot     (div_quot),
    .div_rem      (div_rem),
    .busy         (busy),
    .done         (done),
    .error        (error),
    .best_idx     (best_idx),
    .best_freq    (best_freq)
  );

endmodule

// File: tb/clk_match_sel_tb.sv
module clk_match_sel_tb;

  localparam int FW = 32;
  localparam int ML = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tbl_we = 1'b0;
  logic [4:0]    tbl_waddr = '0;
  logic [FW-1:0] tbl_wdata = '0;
  logic [5:0]    tbl_count = '0;
  logic          start = 1'b0;
  logic [FW-1:0] req_freq = '0;
  logic          exact = 1'b0;
  logic          busy, done, error;
  logic [4:0]    best_idx;
  logic [FW-1:0] best_freq;

  always #5 clk = ~clk;

  clk_match_sel u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .tbl_count(tbl_count), .start(start),
    .req_freq(req_freq), .exact(exact), .busy(busy), .done(done),
    .error(error), .best_idx(best_idx), .best_freq(best_freq)
  );

  typedef struct {
    logic          err;
    int            idx;
    logic [FW-1:0] freq;
    string         tag;
  } exp_t;

  exp_t          exp_q[$];
  logic [FW-1:0] model_tbl [ML];
  int            n_checks = 0;
  int            n_fail   = 0;
  logic          done_prev = 1'b0;

  function automatic exp_t predict(input logic [FW-1:0] q, input logic ex,
                                   input int cnt, input string tag);
    exp_t e;
    longint unsigned best, f, d, rate, gap, rq;
    int n;
    e.err = 1'b1; e.idx = 0; e.freq = '0; e.tag = tag;
    n = (cnt > ML) ? ML : cnt;
    if (q == 0 || n == 0) return e;
    rq = q;
    best = 64'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      f = model_tbl[i];
      d = (f + rq - 1) / rq;
      rate = (d == 0) ? 0 : f / d;
      gap = rq - rate;
      if (gap < best) begin
        best = gap; e.idx = i; e.freq = model_tbl[i]; e.err = 1'b0;
        if (gap == 0) return e;
      end
    end
    if (ex) e.err = 1'b1;
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops one expectation on every rising done
  always @(negedge clk) begin
    if (rst_n && done && !done_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected result", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(error == e.err, {e.tag, " error"}, error, e.err);
        if (!e.err) begin
          chk(best_idx == e.idx, {e.tag, " idx"}, best_idx, e.idx);
          chk(best_freq == e.freq, {e.tag, " freq"}, best_freq, e.freq);
        end
      end
    end
    done_prev = done;
  end

  task automatic wr(input int a, input logic [FW-1:0] v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = 5'(a); tbl_wdata = v;
    model_tbl[a] = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run(input logic [FW-1:0] q, input logic ex, input int cnt,
                     input string tag, output int lat);
    exp_q.push_back(predict(q, ex, cnt, tag));
    @(negedge clk);
    while (busy) @(negedge clk);
    tbl_count = 6'(cnt); req_freq = q; exact = ex; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (exp_q.size() != 0) begin
      @(posedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [FW-1:0] hold_f;
    int hold_i;
    for (int i = 0; i < ML; i++) model_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !error && !busy && best_idx == 0, "reset R8", done, 0);

    // main table, several requests (R2 R3)
    wr(0, 32'd19_200_000); wr(1, 32'd32_000_000); wr(2, 32'd48_000_000);
    wr(3, 32'd64_000_000); wr(4, 32'd96_000_000); wr(5, 32'd100_000_000);
    wr(6, 32'd102_400_000); wr(7, 32'd120_000_000);
    run(32'd1_000_000,  1'b0, 8, "R3 1MHz", lat);
    run(32'd7_300_000,  1'b0, 8, "R3 7.3MHz", lat);
    run(32'd3_686_400,  1'b0, 8, "R2 3.6864MHz", lat);
    run(32'd115_200,    1'b0, 8, "R3 115200", lat);
    run(32'd200_000_000, 1'b0, 8, "R2 above all", lat);
    run(32'd1,          1'b1, 8, "R5 req one", lat);
    run(32'd9_600_000,  1'b1, 8, "R6 exact hit", lat);

    // R1: a perfect entry beyond the count never wins
    wr(8, 32'd7_300_000);
    run(32'd7_300_000, 1'b1, 8, "R1 beyond count", lat);
    run(32'd7_300_000, 1'b1, 9, "R1 within count", lat);
    run(32'd7_300_000, 1'b0, 40, "R1 count clamp", lat);

    // R6: exact demanded, none exact
    wr(0, 32'd10); wr(1, 32'd11); wr(2, 32'd13);
    run(32'd7, 1'b1, 3, "R6 no exact", lat);
    run(32'd7, 1'b0, 3, "R6 best effort", lat);

    // R4: tie goes to lowest index
    wr(0, 32'd10); wr(1, 32'd10); wr(2, 32'd11);
    run(32'd3, 1'b0, 3, "R4 tie", lat);
    chk(best_idx == 0, "R4 tie lowest", best_idx, 0);

    // R9: zero entry
    wr(0, 32'd0); wr(1, 32'd5);
    run(32'd4, 1'b0, 2, "R9 zero then five", lat);
    run(32'd4, 1'b0, 1, "R9 zero only", lat);
    chk(best_freq == 0 && !error, "R9 zero entry freq", best_freq, 0);

    // R7: empty table and zero request
    run(32'd4, 1'b0, 0, "R7 empty", lat);
    run(32'd0, 1'b0, 2, "R7 zero req", lat);

    // R5: early stop at index 2 of 20
    for (int i = 0; i < 20; i++) wr(i, 32'(1000 + 37 * i + 1));
    wr(2, 32'd8000); wr(10, 32'd16000);
    run(32'd4000, 1'b1, 20, "R5 early stop", lat);
    chk(lat <= 3 * (2 * FW + 8) + 4, "R5 latency", lat, 3 * (2 * FW + 8) + 4);

    // R8: stray start during a search is ignored; result then held
    exp_q.push_back(predict(32'd333, 1'b0, 20, "R8 ignored start"));
    @(negedge clk);
    tbl_count = 6'd20; req_freq = 32'd333; exact = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    req_freq = 32'd0; exact = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(posedge clk);
    @(negedge clk);
    hold_f = best_freq; hold_i = best_idx;
    repeat (10) @(negedge clk);
    chk(!busy && done, "R8 no restart", busy, 0);
    chk(best_freq == hold_f && best_idx == hold_i, "R8 hold", best_freq, hold_f);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule